// File: doc/BRIEF.md
# Overflow Signature Filters for Transactional Conflict Detection

The block keeps two Bloom-filter address signatures for the transaction that runs on each core. One signature records the lines the transaction has read and the other records the lines it has written. A signature covers only lines that have left the last-level cache. When the last-level cache controller evicts a line, it sends the line address, a mask of the speculative readers of that line and, when there is one, the identity of its single speculative writer. The block sets the hashed bits in the matching signatures.

When a request misses the whole cache hierarchy, it is looked up against the signatures of every core other than the requester's own. One cycle later the block returns a per-core conflict mask and an abort flag. A read conflicts only with a hit in a write signature. A write conflicts with a hit in either kind of signature. The requester aborts on any conflict. Fetching a line back from memory and making a lookup leave the signatures unchanged.

When a transaction commits or aborts, its pair of signatures can be cleared in one cycle. Each signature can also be read out and written back one word at a time, so that it can be saved and restored with the thread context.

Top module: `ovf_sig_filter`

## Requirements
- R1: An eviction with `evict_valid` high sets the hashed bits of `evict_line` in the read signature of every core c whose bit `evict_readers[c]` is 1.
- R2: An eviction with `evict_has_writer` high also sets the hashed bits in the write signature of core `evict_writer` and in no other write signature.
- R3: Hash index j (j = 0 and 1 by default, 10-bit indices) is the XOR of all 10-bit slices of the line address after that address has been rotated left by 7*j bits. Slice 0 is bits 9:0, and the top slice is padded with zeros. A signature reports presence only when every one of its indexed bits is 1.
- R4: For a read lookup (`miss_is_write` = 0), core c is flagged when its write signature reports presence. A read-signature hit alone never flags it.
- R5: For a write lookup (`miss_is_write` = 1), core c is flagged when its read signature or its write signature reports presence.
- R6: The signatures of `miss_core` are never consulted. `resp_hit_cores[c]` is 1 exactly for the flagged cores, and `resp_abort` is 1 when any bit of the mask is 1.
- R7: `resp_valid`, `resp_abort` and `resp_hit_cores` appear one cycle after `miss_valid`. The response reflects the signatures as they were before any insert, clear or load made in the same cycle as the lookup. When there is no request, `resp_valid` is 0 and the mask is 0.
- R8: `clear_valid` zeroes both signatures of `clear_core` and leaves the other cores untouched. A same-cycle insert into that core is discarded.
- R9: `save_valid` returns bits [32*w+31 : 32*w] of the chosen signature (`save_is_write` = 0 for read, 1 for write; w = `save_word`) on `save_data` one cycle later, with `save_resp_valid` high. `load_valid` overwrites that word of the chosen signature, taking effect after any same-cycle clear or insert.
- R10: Reset empties every signature and drives every output low. An empty signature never flags a conflict.
- R11: Lookups never insert into or remove from any signature, so a line that is only fetched back or probed is not recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evict_valid | input | 1 | Eviction insert request |
| evict_line | input | ADDR_W | Line address of the evicted line |
| evict_readers | input | NCORES | One bit per speculative reader core |
| evict_has_writer | input | 1 | Evicted line has a speculative writer |
| evict_writer | input | CORE_W | Writer core index |
| miss_valid | input | 1 | Lookup request from a hierarchy miss |
| miss_line | input | ADDR_W | Line address being looked up |
| miss_core | input | CORE_W | Requesting core (its own signatures are excluded) |
| miss_is_write | input | 1 | 1 for a write lookup, 0 for a read |
| resp_valid | output | 1 | Lookup response valid |
| resp_abort | output | 1 | Requester must abort |
| resp_hit_cores | output | NCORES | Cores whose signatures conflict |
| clear_valid | input | 1 | Clear both signatures of one core |
| clear_core | input | CORE_W | Core to clear |
| save_valid | input | 1 | Read one signature word |
| save_core | input | CORE_W | Core to read |
| save_is_write | input | 1 | 0 selects the read signature, 1 the write signature |
| save_word | input | WIDX_W | Word index within the signature |
| save_resp_valid | output | 1 | Saved word valid |
| save_data | output | WORD_W | Saved word |
| load_valid | input | 1 | Write one signature word |
| load_core | input | CORE_W | Core to write |
| load_is_write | input | 1 | 0 selects the read signature, 1 the write signature |
| load_word | input | WIDX_W | Word index within the signature |
| load_data | input | WORD_W | Word to write |

## Verification
The bench builds the block with its defaults: four cores, 1024-bit signatures, two hashes, a 32-bit address and 32-bit save words. Four cores are enough for one eviction to name several readers together with a distinct writer and a separate requester, which brings the per-core mask, the exclusion of the requester's own signatures and the read/write asymmetry within reach. The 32-bit word interface lets the bench saturate a single word by a load and then find an address whose two hash indices both fall in that word. This forces a hit that depends only on the restore path.

// File: rtl/ovf_sig_pkg.sv
package ovf_sig_pkg;
  typedef enum logic {
    SIG_RD = 1'b0,
    SIG_WR = 1'b1
  } sig_kind_e;
endpackage

// File: rtl/ovf_sig_hash.sv
module ovf_sig_hash #(
  parameter int ADDR_W   = 32,
  parameter int SIG_BITS = 1024,
  parameter int NHASH    = 2,
  parameter int ROT      = 7,
  parameter int IDX_W    = $clog2(SIG_BITS)
) (
  input  logic [ADDR_W-1:0]             line,
  output logic [NHASH-1:0][IDX_W-1:0]   idx
);
  localparam int NSLICE = (ADDR_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W  = NSLICE * IDX_W;

  for (genvar j = 0; j < NHASH; j++) begin : g_fn
    localparam int SH = (ROT * j) % ADDR_W;
    logic [ADDR_W-1:0] rot;
    logic [PAD_W-1:0]  padded;
    logic [IDX_W-1:0]  acc;

    assign rot    = (line << SH) | (line >> (ADDR_W - SH));
    assign padded = PAD_W'(rot);

    always_comb begin
      acc = '0;
      for (int s = 0; s < NSLICE; s++) acc = acc ^ padded[s*IDX_W +: IDX_W];
    end

    assign idx[j] = acc;
  end
endmodule

// File: rtl/ovf_sig_bank.sv
module ovf_sig_bank #(
  parameter int SIG_BITS = 1024,
  parameter int NHASH    = 2,
  parameter int WORD_W   = 32,
  parameter int IDX_W    = $clog2(SIG_BITS),
  parameter int WIDX_W   = $clog2(SIG_BITS / WORD_W)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr,
  input  logic                         ins_en,
  input  logic [NHASH-1:0][IDX_W-1:0]  ins_idx,
  input  logic [NHASH-1:0][IDX_W-1:0]  probe_idx,
  output logic                         probe_hit,
  input  logic                         ld_en,
  input  logic [WIDX_W-1:0]            ld_word,
  input  logic [WORD_W-1:0]            ld_data,
  input  logic [WIDX_W-1:0]            rd_word,
  output logic [WORD_W-1:0]            rd_data
);
  logic [SIG_BITS-1:0] sig, sig_nxt;

  // clear dominates insert; a word load lands on top of both
  always_comb begin
    sig_nxt = clr ? '0 : sig;
    if (!clr && ins_en)
      for (int j = 0; j < NHASH; j++) sig_nxt[ins_idx[j]] = 1'b1;
    if (ld_en) sig_nxt[ld_word*WORD_W +: WORD_W] = ld_data;
  end

  always_ff @(posedge clk) begin
    if (rst) sig <= '0;
    else     sig <= sig_nxt;
  end

  always_comb begin
    probe_hit = 1'b1;
    for (int j = 0; j < NHASH; j++) probe_hit = probe_hit & sig[probe_idx[j]];
  end

  assign rd_data = sig[rd_word*WORD_W +: WORD_W];
endmodule

// File: rtl/ovf_sig_filter.sv
module ovf_sig_filter #(
  parameter int NCORES   = 4,
  parameter int ADDR_W   = 32,
  parameter int SIG_BITS = 1024,
  parameter int NHASH    = 2,
  parameter int HASH_ROT = 7,
  parameter int WORD_W   = 32,
  parameter int CORE_W   = $clog2(NCORES),
  parameter int WIDX_W   = $clog2(SIG_BITS / WORD_W)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                evict_valid,
  input  logic [ADDR_W-1:0]   evict_line,
  input  logic [NCORES-1:0]   evict_readers,
  input  logic                evict_has_writer,
  input  logic [CORE_W-1:0]   evict_writer,
  input  logic                miss_valid,
  input  logic [ADDR_W-1:0]   miss_line,
  input  logic [CORE_W-1:0]   miss_core,
  input  logic                miss_is_write,
  output logic                resp_valid,
  output logic                resp_abort,
  output logic [NCORES-1:0]   resp_hit_cores,
  input  logic                clear_valid,
  input  logic [CORE_W-1:0]   clear_core,
  input  logic                save_valid,
  input  logic [CORE_W-1:0]   save_core,
  input  logic                save_is_write,
  input  logic [WIDX_W-1:0]   save_word,
  output logic                save_resp_valid,
  output logic [WORD_W-1:0]   save_data,
  input  logic                load_valid,
  input  logic [CORE_W-1:0]   load_core,
  input  logic                load_is_write,
  input  logic [WIDX_W-1:0]   load_word,
  input  logic [WORD_W-1:0]   load_data
);
  import ovf_sig_pkg::*;

  localparam int IDX_W = $clog2(SIG_BITS);
  localparam int NKIND = 2;

  logic [NHASH-1:0][IDX_W-1:0] ev_idx, lk_idx;
  logic [NCORES-1:0]           rd_hit, wr_hit, hit_mask;
  logic [WORD_W-1:0]           bank_word [NCORES][NKIND];

  ovf_sig_hash #(.ADDR_W(ADDR_W), .SIG_BITS(SIG_BITS), .NHASH(NHASH),
                 .ROT(HASH_ROT), .IDX_W(IDX_W))
    u_hash_ev (.line(evict_line), .idx(ev_idx));

  ovf_sig_hash #(.ADDR_W(ADDR_W), .SIG_BITS(SIG_BITS), .NHASH(NHASH),
                 .ROT(HASH_ROT), .IDX_W(IDX_W))
    u_hash_lk (.line(miss_line), .idx(lk_idx));

  for (genvar c = 0; c < NCORES; c++) begin : g_core
    logic clr_c;
    assign clr_c = clear_valid && (clear_core == CORE_W'(c));

    for (genvar k = 0; k < NKIND; k++) begin : g_kind
      logic ins_k, ld_k, hit_k;
      if (k == int'(SIG_RD)) begin : g_rd
        assign ins_k = evict_valid && evict_readers[c];
      end else begin : g_wr
        assign ins_k = evict_valid && evict_has_writer && (evict_writer == CORE_W'(c));
      end
      assign ld_k = load_valid && (load_core == CORE_W'(c)) && (load_is_write == k[0]);

      ovf_sig_bank #(.SIG_BITS(SIG_BITS), .NHASH(NHASH), .WORD_W(WORD_W),
                     .IDX_W(IDX_W), .WIDX_W(WIDX_W))
        u_bank (
          .clk(clk), .rst(rst), .clr(clr_c),
          .ins_en(ins_k), .ins_idx(ev_idx),
          .probe_idx(lk_idx), .probe_hit(hit_k),
          .ld_en(ld_k), .ld_word(load_word), .ld_data(load_data),
          .rd_word(save_word), .rd_data(bank_word[c][k])
        );
    end

    assign rd_hit[c] = g_kind[0].hit_k;
    assign wr_hit[c] = g_kind[1].hit_k;
    assign hit_mask[c] = (miss_core != CORE_W'(c)) &&
                         (wr_hit[c] || (miss_is_write && rd_hit[c]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid     <= 1'b0;
      resp_abort     <= 1'b0;
      resp_hit_cores <= '0;
    end else begin
      resp_valid     <= miss_valid;
      resp_abort     <= miss_valid && (|hit_mask);
      resp_hit_cores <= miss_valid ? hit_mask : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      save_resp_valid <= 1'b0;
      save_data       <= '0;
    end else begin
      save_resp_valid <= save_valid;
      if (save_valid) save_data <= bank_word[save_core][save_is_write];
    end
  end
endmodule

// File: rtl/ovf_sig_filter_chk.sv
module ovf_sig_filter_chk #(
  parameter int NCORES = 4,
  parameter int CORE_W = $clog2(NCORES)
) (
  input logic              clk,
  input logic              rst,
  input logic              miss_valid,
  input logic [CORE_W-1:0] miss_core,
  input logic              resp_valid,
  input logic              resp_abort,
  input logic [NCORES-1:0] resp_hit_cores,
  input logic              save_valid,
  input logic              save_resp_valid
);
  p_resp_follows_req_r7: assert property (@(posedge clk) disable iff (rst)
    miss_valid |=> resp_valid);

  p_resp_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !miss_valid |=> (!resp_valid && !resp_abort && resp_hit_cores == '0));

  p_own_core_excluded_r6: assert property (@(posedge clk) disable iff (rst)
    miss_valid |=> !resp_hit_cores[$past(miss_core)]);

  p_abort_has_cause_r6: assert property (@(posedge clk) disable iff (rst)
    resp_abort |-> (resp_valid && resp_hit_cores != '0));

  p_save_latency_r9: assert property (@(posedge clk) disable iff (rst)
    save_valid |=> save_resp_valid);

  p_reset_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!resp_valid && !save_resp_valid));
endmodule

bind ovf_sig_filter ovf_sig_filter_chk #(.NCORES(NCORES), .CORE_W(CORE_W)) u_chk (
  .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_core(miss_core),
  .resp_valid(resp_valid), .resp_abort(resp_abort), .resp_hit_cores(resp_hit_cores),
  .save_valid(save_valid), .save_resp_valid(save_resp_valid)
);

// File: tb/ovf_sig_filter_tb.sv
`timescale 1ns/1ps
module ovf_sig_filter_tb;
  localparam int NC = 4, AW = 32, SB = 1024, WW = 32, CW = 2, XW = 5;

  logic clk = 1'b0, rst = 1'b1;
  always #10 clk = ~clk;

  logic          evict_valid = 0, evict_has_writer = 0;
  logic [AW-1:0] evict_line = 0;
  logic [NC-1:0] evict_readers = 0;
  logic [CW-1:0] evict_writer = 0;
  logic          miss_valid = 0, miss_is_write = 0;
  logic [AW-1:0] miss_line = 0;
  logic [CW-1:0] miss_core = 0;
  logic          resp_valid, resp_abort;
  logic [NC-1:0] resp_hit_cores;
  logic          clear_valid = 0;
  logic [CW-1:0] clear_core = 0;
  logic          save_valid = 0, save_is_write = 0, save_resp_valid;
  logic [CW-1:0] save_core = 0;
  logic [XW-1:0] save_word = 0;
  logic [WW-1:0] save_data;
  logic          load_valid = 0, load_is_write = 0;
  logic [CW-1:0] load_core = 0;
  logic [XW-1:0] load_word = 0;
  logic [WW-1:0] load_data = 0;

  ovf_sig_filter u_dut (.*);

  int checks = 0, failures = 0;
  bit done = 0;

  // reference signatures built from the requirement text
  logic [SB-1:0] m_rd [NC];
  logic [SB-1:0] m_wr [NC];

  typedef struct { logic abort; logic [NC-1:0] mask; string tag; } exp_t;
  exp_t sb_q[$];

  function automatic logic [9:0] hidx(input logic [31:0] line, input int j);
    logic [31:0] r;
    logic [9:0] a;
    r = (line << (7*j)) | (line >> (32 - 7*j));
    a = '0;
    for (int i = 0; i < 32; i++) a[i % 10] = a[i % 10] ^ r[i];
    return a;
  endfunction

  function automatic bit present(input logic [SB-1:0] s, input logic [31:0] line);
    return s[hidx(line, 0)] && s[hidx(line, 1)];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle of stimulus; lookup expectation taken before same-cycle updates (R7)
  task automatic step(input bit ev, input logic [31:0] eline, input logic [NC-1:0] erd,
                      input bit ehw, input int ewr,
                      input bit mv, input logic [31:0] mline, input int mcore, input bit mwr,
                      input bit cv, input int ccore, input string tag);
    exp_t e;
    @(negedge clk);
    evict_valid = ev; evict_line = eline; evict_readers = erd;
    evict_has_writer = ehw; evict_writer = CW'(ewr);
    miss_valid = mv; miss_line = mline; miss_core = CW'(mcore); miss_is_write = mwr;
    clear_valid = cv; clear_core = CW'(ccore);
    if (mv) begin
      e.mask = '0;
      for (int c = 0; c < NC; c++)
        if (c != mcore && (present(m_wr[c], mline) || (mwr && present(m_rd[c], mline))))
          e.mask[c] = 1'b1;
      e.abort = |e.mask;
      e.tag = tag;
      sb_q.push_back(e);
    end
    for (int c = 0; c < NC; c++) begin
      if (cv && ccore == c) begin
        m_rd[c] = '0; m_wr[c] = '0;
      end else if (ev) begin
        if (erd[c]) begin m_rd[c][hidx(eline,0)] = 1'b1; m_rd[c][hidx(eline,1)] = 1'b1; end
        if (ehw && ewr == c) begin m_wr[c][hidx(eline,0)] = 1'b1; m_wr[c][hidx(eline,1)] = 1'b1; end
      end
    end
  endtask

  task automatic idle();
    @(negedge clk);
    evict_valid = 0; miss_valid = 0; clear_valid = 0; save_valid = 0; load_valid = 0;
  endtask

  task automatic lookup(input logic [31:0] line, input int core, input bit wr, input string tag);
    step(0, 0, '0, 0, 0, 1, line, core, wr, 0, 0, tag);
    idle();
  endtask

  task automatic evict(input logic [31:0] line, input logic [NC-1:0] rd, input bit hw, input int w);
    step(1, line, rd, hw, w, 0, 0, 0, 0, 0, 0, "");
    idle();
  endtask

  task automatic save_chk(input int core, input bit kind, input int w, input string tag);
    logic [WW-1:0] exp;
    @(negedge clk);
    save_valid = 1; save_core = CW'(core); save_is_write = kind; save_word = XW'(w);
    exp = kind ? m_wr[core][w*WW +: WW] : m_rd[core][w*WW +: WW];
    @(negedge clk);
    save_valid = 0;
    check(save_resp_valid === 1'b1 && save_data === exp, tag, {31'b0, save_resp_valid, save_data}, {32'b1, exp});
  endtask

  task automatic load_word_t(input int core, input bit kind, input int w, input logic [WW-1:0] d);
    @(negedge clk);
    load_valid = 1; load_core = CW'(core); load_is_write = kind; load_word = XW'(w); load_data = d;
    if (kind) m_wr[core][w*WW +: WW] = d; else m_rd[core][w*WW +: WW] = d;
    @(negedge clk);
    load_valid = 0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && resp_valid) begin
      if (sb_q.size() == 0) begin
        check(0, "R7 unexpected response", 64'(resp_valid), 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(resp_abort === e.abort && resp_hit_cores === e.mask, e.tag,
              {59'b0, resp_abort, resp_hit_cores}, {59'b0, e.abort, e.mask});
      end
    end
  end

  initial begin
    #4_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] A, B, E, F, G, H;
    for (int c = 0; c < NC; c++) begin m_rd[c] = '0; m_wr[c] = '0; end
    A = 32'h0001_2345; B = 32'h00AB_CDEF; E = 32'h0F00_0F0F; F = 32'h1234_5678; G = 32'h0000_7777;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(resp_valid === 0 && resp_abort === 0 && save_resp_valid === 0, "R10 reset outputs",
          {resp_valid, resp_abort, save_resp_valid}, 0);
    save_chk(0, 0, 0, "R10 empty after reset");
    lookup(A, 1, 1, "R10 empty signatures no conflict");

    // R1 multiple readers; R4 read ignores read hits; R5 write sees read hits
    evict(A, 4'b0011, 0, 0);
    lookup(A, 2, 1, "R5 write vs readers 0,1 (R1)");
    lookup(A, 2, 0, "R4 read vs read signatures only");
    lookup(A, 0, 1, "R6 own core excluded");
    save_chk(0, 0, hidx(A,0) / 32, "R3 hash index 0 bit set");
    save_chk(1, 0, hidx(A,1) / 32, "R3 hash index 1 bit set");

    // R2 single writer
    evict(B, 4'b0000, 1, 3);
    lookup(B, 0, 0, "R2 read vs writer core3 (R4)");
    lookup(B, 3, 1, "R6 writer excluded from own lookup");
    save_chk(2, 1, hidx(B,0) / 32, "R2 other write signature untouched");

    // R11 lookups do not insert
    lookup(G, 1, 1, "R11 first probe");
    lookup(G, 2, 0, "R11 probe left no trace");

    // R7 same-cycle insert not visible, visible next
    step(1, E, 4'b0010, 0, 0, 1, E, 0, 1, 0, 0, "R7 same-cycle insert hidden");
    step(0, 0, '0, 0, 0, 1, E, 0, 1, 0, 0, "R7 insert visible next lookup");
    idle();

    // R8 clear of core1; clear beats same-cycle insert
    step(0, 0, '0, 0, 0, 0, 0, 0, 0, 1, 1, "");
    idle();
    lookup(A, 2, 1, "R8 core1 cleared, core0 kept");
    lookup(E, 0, 1, "R8 cleared signature empty");
    step(1, F, 4'b0001, 1, 0, 0, 0, 0, 0, 1, 0, "");
    idle();
    lookup(F, 2, 1, "R8 clear beat same-cycle insert");
    save_chk(0, 0, hidx(A,0) / 32, "R8 cleared core0 read word");

    // R9 load a full word then hit via an address hashing into it
    H = 0;
    for (int a = 1; a < 500000; a++)
      if (hidx(a,0) / 32 == 5 && hidx(a,1) / 32 == 5) begin H = a; break; end
    load_word_t(2, 1, 5, 32'hFFFF_FFFF);
    save_chk(2, 1, 5, "R9 save returns loaded word");
    lookup(H, 0, 0, "R9 loaded word produces hit");
    load_word_t(2, 1, 5, 32'h0);
    lookup(H, 0, 0, "R9 reloaded zero word no hit");

    // R10 empty signatures never conflict
    for (int c = 0; c < NC; c++) begin
      step(0, 0, '0, 0, 0, 0, 0, 0, 0, 1, c, "");
      idle();
    end
    lookup(A, 3, 1, "R10 all empty A");
    lookup(B, 1, 1, "R10 all empty B");
    repeat (3) idle();
    check(sb_q.size() == 0, "R7 responses all returned", 64'(sb_q.size()), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule